// File: doc/BRIEF.md
# March memory test controller

This block runs March-style tests on a synchronous single-port SRAM. A test is a list of elements. Each element has an address order (ascending, descending or free) and a counting method (linear or address-complement). It also holds a short list of operations, each a write or a read-and-compare of a 0 or 1 value. The element list arrives as a packed parameter word on `prog_i`. The data background arrives on `bg_i`: a value 0 maps to the background word and a value 1 maps to its inverse.

A `start_i` pulse while idle launches the run. The controller then issues exactly one memory access per clock until the last operation of the last element, with no idle cycles between operations, addresses or elements. Read data returns one cycle after the access. The controller compares it in the following cycle. On the first mismatch it latches a sticky fail flag and the failing address, and the run carries on to the end. A one-cycle `done_o` pulse marks the end of the run, and the fail outputs are final when it appears.

Top module: `march_ctrl`

## Requirements
- R1: After reset `busy_o`, `mem_en_o`, `done_o` and `fail_o` are 0, `fail_addr_o` is 0, and nothing is accessed until a start.
- R2: `start_i` sampled while idle starts a run, and the first access appears in the next cycle with `busy_o` high. `start_i` while busy is ignored: the access sequence is unchanged and the fail state is kept.
- R3: Within an element, every operation is applied in list order to one address before the address moves. Each operation is 2 bits: bit 0 selects write (1) or read (0), and bit 1 is the data value.
- R4: The order field of an element is bits [1:0]: 0 free, 1 up, 2 down. Bit 2 selects address-complement counting. Linear up visits 0,1,..,N-1, and the free order behaves as linear up.
- R5: Linear down visits N-1, N-2, .., 0.
- R6: Address-complement up alternates between an ascending low counter and a descending high counter. For N=8 the order is 0,7,1,6,2,5,3,4.
- R7: Address-complement down is the exact reverse of address-complement up. For N=8 the order is 4,3,5,2,6,1,7,0.
- R8: From the first access to the last, `mem_en_o` is high in every cycle, element boundaries included.
- R9: A value-0 operation uses `bg_i` and a value-1 operation uses `~bg_i`, both as write data and as the expected read data.
- R10: The first read whose returned data differs from its expectation sets `fail_o` and loads `fail_addr_o` two cycles after the access. Both hold until the next accepted start, and the run continues.
- R11: `done_o` is high for exactly one cycle, two cycles after the last access. `busy_o` is low from the cycle after the last access.
- R12: An element holds from 1 to MAX_OPS operations in bits [4:3] as count minus one, followed by the operation slots from bit 5, any mix of reads and writes. `last_elem_i` gives the index of the final element.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, taken while idle |
| last_elem_i | input | ELC_W | Index of the last element to run |
| prog_i | input | MAX_ELEM*EW | Packed element list, element e at bits [e*EW +: EW] |
| bg_i | input | DATA_W | Data background word |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| fail_o | output | 1 | Sticky mismatch flag |
| fail_addr_o | output | ADDR_W | Address of the first mismatch |
| mem_en_o | output | 1 | Memory access enable |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_rdata_i | input | DATA_W | Memory read data, valid one cycle after a read |

## Verification
The hardest cases to reach are a mismatch that lands mid-element under address-complement counting, and a start request that arrives while a failing run is still in flight. The bench memory model flips chosen bits on reads at a chosen address. It places that fault inside the address-complement elements and also on the last address of a descending element. In one failing run it raises `start_i` part way through, so both the stickiness of the fail state and the ignored restart show up at the ports. It then runs a clean test to see the flag clear.

// File: rtl/march_pkg.sv
package march_pkg;
  localparam int ORD_W  = 2;
  localparam int OP_W   = 2;
  localparam int OP_WR  = 0;
  localparam int OP_VAL = 1;

  typedef enum logic [ORD_W-1:0] {
    ORD_ANY  = 2'd0,
    ORD_UP   = 2'd1,
    ORD_DOWN = 2'd2,
    ORD_RSVD = 2'd3
  } order_e;
endpackage

// File: rtl/march_addr_gen.sv
module march_addr_gen #(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic              down_i,
  input  logic              ac_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);
  localparam logic [ADDR_W-1:0] ADDR_MAX = '1;
  localparam logic [ADDR_W-1:0] ADDR_LOW = ADDR_MAX >> 1;
  localparam logic [ADDR_W-1:0] ADDR_MID = ADDR_MAX ^ ADDR_LOW;

  logic [ADDR_W-1:0] a_q, b_q, cnt_q;
  logic              ph_q, down_q, ac_q;

  // a counts up (or down when linear-down), b counts down; ph selects b
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q    <= '0;
      b_q    <= '0;
      cnt_q  <= '0;
      ph_q   <= 1'b0;
      down_q <= 1'b0;
      ac_q   <= 1'b0;
    end else if (load_i) begin
      down_q <= down_i;
      ac_q   <= ac_i;
      ph_q   <= 1'b0;
      cnt_q  <= '0;
      if (ac_i) begin
        a_q <= down_i ? ADDR_MID : '0;
        b_q <= down_i ? ADDR_LOW : ADDR_MAX;
      end else begin
        a_q <= down_i ? ADDR_MAX : '0;
        b_q <= ADDR_MAX;
      end
    end else if (step_i) begin
      cnt_q <= cnt_q + 1'b1;
      if (ac_q) begin
        ph_q <= ~ph_q;
        if (!ph_q) a_q <= a_q + 1'b1;
        else       b_q <= b_q - 1'b1;
      end else if (down_q) begin
        a_q <= a_q - 1'b1;
      end else begin
        a_q <= a_q + 1'b1;
      end
    end
  end

  assign addr_o = (ac_q && ph_q) ? b_q : a_q;
  assign last_o = (cnt_q == ADDR_MAX);

  assert_lin_up_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !load_i && !ac_q && !down_q |=> addr_o == $past(addr_o) + 1'b1);
  assert_lin_down_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !load_i && !ac_q && down_q |=> addr_o == $past(addr_o) - 1'b1);
  assert_ac_pair_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !load_i && ac_q && !ph_q |=> addr_o == ~$past(addr_o));
endmodule

// File: rtl/march_chk.sv
module march_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              rd_vld_i,
  input  logic [DATA_W-1:0] exp_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              last_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              fail_o,
  output logic [ADDR_W-1:0] fail_addr_o,
  output logic              done_o
);
  logic              p_vld_q, p_last_q, fail_q, done_q;
  logic [DATA_W-1:0] p_exp_q;
  logic [ADDR_W-1:0] p_addr_q, fail_addr_q;
  logic              mismatch;

  // stage aligns expectation with the SRAM's one-cycle read latency
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_vld_q  <= 1'b0;
      p_last_q <= 1'b0;
      p_exp_q  <= '0;
      p_addr_q <= '0;
      done_q   <= 1'b0;
    end else begin
      p_vld_q  <= rd_vld_i;
      p_last_q <= last_i;
      p_exp_q  <= exp_i;
      p_addr_q <= addr_i;
      done_q   <= p_last_q;
    end
  end

  assign mismatch = p_vld_q && (rdata_i != p_exp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fail_q      <= 1'b0;
      fail_addr_q <= '0;
    end else if (clear_i) begin
      fail_q      <= 1'b0;
      fail_addr_q <= '0;
    end else if (mismatch && !fail_q) begin
      fail_q      <= 1'b1;
      fail_addr_q <= p_addr_q;
    end
  end

  assign fail_o      = fail_q;
  assign fail_addr_o = fail_addr_q;
  assign done_o      = done_q;

  assert_done_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_fail_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o && !clear_i |=> fail_o);
  assert_fail_addr_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o && !clear_i |=> $stable(fail_addr_o));
endmodule

// File: rtl/march_ctrl.sv
module march_ctrl
  import march_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 8,
  parameter int MAX_ELEM = 8,
  parameter int MAX_OPS  = 4,
  localparam int OPC_W   = $clog2(MAX_OPS),
  localparam int ELC_W   = $clog2(MAX_ELEM),
  localparam int OPS_LSB = ORD_W + 1 + OPC_W,
  localparam int EW      = OPS_LSB + OP_W * MAX_OPS
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [ELC_W-1:0]       last_elem_i,
  input  logic [MAX_ELEM*EW-1:0] prog_i,
  input  logic [DATA_W-1:0]      bg_i,
  output logic                   busy_o,
  output logic                   done_o,
  output logic                   fail_o,
  output logic [ADDR_W-1:0]      fail_addr_o,
  output logic                   mem_en_o,
  output logic                   mem_we_o,
  output logic [ADDR_W-1:0]      mem_addr_o,
  output logic [DATA_W-1:0]      mem_wdata_o,
  input  logic [DATA_W-1:0]      mem_rdata_i
);
  order_e           elem_ord  [MAX_ELEM];
  logic             elem_ac   [MAX_ELEM];
  logic [OPC_W-1:0] elem_nops [MAX_ELEM];
  logic [OP_W-1:0]  elem_op   [MAX_ELEM][MAX_OPS];

  for (genvar e = 0; e < MAX_ELEM; e++) begin : g_elem
    localparam int BASE = e * EW;
    assign elem_ord[e]  = order_e'(prog_i[BASE +: ORD_W]);
    assign elem_ac[e]   = prog_i[BASE + ORD_W];
    assign elem_nops[e] = prog_i[BASE + ORD_W + 1 +: OPC_W];
    for (genvar j = 0; j < MAX_OPS; j++) begin : g_op
      assign elem_op[e][j] = prog_i[BASE + OPS_LSB + j*OP_W +: OP_W];
    end
  end

  logic              run_q;
  logic [ELC_W-1:0]  elem_q, nxt_elem;
  logic [OPC_W-1:0]  op_q;
  logic [OP_W-1:0]   cur_op;
  logic              start_ok, op_last, elem_last, addr_last, elem_adv, fin;
  logic              gen_load, gen_step, gen_down, gen_ac;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] op_data;

  assign start_ok  = start_i && !run_q;
  assign cur_op    = elem_op[elem_q][op_q];
  assign op_last   = (op_q == elem_nops[elem_q]);
  assign elem_last = (elem_q == last_elem_i);
  assign elem_adv  = run_q && op_last && addr_last;
  assign fin       = elem_adv && elem_last;
  assign nxt_elem  = start_ok ? '0 : elem_q + 1'b1;
  assign gen_load  = start_ok || (elem_adv && !elem_last);
  assign gen_step  = run_q && op_last && !addr_last;
  assign gen_down  = (elem_ord[nxt_elem] == ORD_DOWN);
  assign gen_ac    = elem_ac[nxt_elem];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      elem_q <= '0;
      op_q   <= '0;
    end else if (start_ok) begin
      run_q  <= 1'b1;
      elem_q <= '0;
      op_q   <= '0;
    end else if (run_q) begin
      if (op_last) begin
        op_q <= '0;
        if (addr_last) begin
          if (elem_last) run_q  <= 1'b0;
          else           elem_q <= elem_q + 1'b1;
        end
      end else begin
        op_q <= op_q + 1'b1;
      end
    end
  end

  march_addr_gen #(.ADDR_W(ADDR_W)) u_addr_gen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (gen_load),
    .step_i (gen_step),
    .down_i (gen_down),
    .ac_i   (gen_ac),
    .addr_o (addr),
    .last_o (addr_last)
  );

  assign op_data     = cur_op[OP_VAL] ? ~bg_i : bg_i;
  assign mem_en_o    = run_q;
  assign mem_we_o    = run_q && cur_op[OP_WR];
  assign mem_addr_o  = addr;
  assign mem_wdata_o = op_data;
  assign busy_o      = run_q;

  march_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (start_ok),
    .rd_vld_i    (run_q && !cur_op[OP_WR]),
    .exp_i       (op_data),
    .addr_i      (addr),
    .last_i      (fin),
    .rdata_i     (mem_rdata_i),
    .fail_o      (fail_o),
    .fail_addr_o (fail_addr_o),
    .done_o      (done_o)
  );

  assert_addr_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && !op_last |=> mem_addr_o == $past(mem_addr_o));
  assert_back_to_back_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_en_o && !fin |=> mem_en_o);
  assert_start_access_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_ok |=> mem_en_o);
endmodule

// File: tb/march_ctrl_bench.sv
`timescale 1ns/1ps
module march_ctrl_bench;
  localparam int ADDR_W = 4, DATA_W = 8, MAX_ELEM = 8, MAX_OPS = 4;
  localparam int OPC_W = 2, ELC_W = 3, EW = 13, N = 1 << ADDR_W;
  localparam int WD_LIMIT = 20000;
  localparam logic [1:0] R0 = 2'b00, W0 = 2'b01, R1 = 2'b10, W1 = 2'b11;
  localparam logic [1:0] ANY = 2'd0, UP = 2'd1, DN = 2'd2;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [ELC_W-1:0] last_elem = '0;
  logic [MAX_ELEM*EW-1:0] prog = '0;
  logic [DATA_W-1:0] bg = '0, wdata, rdata = '0;
  logic busy, done, fail, mem_en, mem_we;
  logic [ADDR_W-1:0] fail_addr, addr;

  always #2 clk = ~clk;

  march_ctrl u_march_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .last_elem_i(last_elem),
    .prog_i(prog), .bg_i(bg), .busy_o(busy), .done_o(done), .fail_o(fail),
    .fail_addr_o(fail_addr), .mem_en_o(mem_en), .mem_we_o(mem_we),
    .mem_addr_o(addr), .mem_wdata_o(wdata), .mem_rdata_i(rdata));

  logic [DATA_W-1:0] mem [N];
  logic [ADDR_W-1:0] f_addr = '0;
  logic [DATA_W-1:0] f_mask = '0;

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem[addr] <= wdata;
      else rdata <= mem[addr] ^ ((addr == f_addr) ? f_mask : '0);
    end
  end

  typedef struct { bit we; int a; logic [DATA_W-1:0] d; string at; string ot; } acc_t;
  acc_t q[$];
  int n_chk = 0, n_fail = 0, cyc = 0, cd = -1, fail_cyc = 0;
  bit exp_fail = 0, timeout = 0;
  int exp_faddr = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [EW-1:0] mk(logic [1:0] ord, bit ac, int n, logic [7:0] ops);
    logic [OPC_W-1:0] nm = OPC_W'(n - 1);
    return {ops, nm, ac, ord};
  endfunction

  function automatic int seq_addr(int k, bit down, bit ac);
    int kk;
    if (!ac) return down ? N - 1 - k : k;
    kk = down ? N - 1 - k : k;
    return (kk % 2 == 0) ? kk / 2 : N - 1 - (kk - 1) / 2;
  endfunction

  task automatic build();
    q.delete();
    for (int e = 0; e <= int'(last_elem); e++) begin
      logic [EW-1:0] el = prog[e*EW +: EW];
      bit dn = (el[1:0] == DN);
      bit ac = el[2];
      int n = int'(el[4:3]) + 1;
      for (int k = 0; k < N; k++) begin
        for (int j = 0; j < n; j++) begin
          acc_t it;
          logic [1:0] op = el[5 + 2*j +: 2];
          it.we = op[0];
          it.a  = seq_addr(k, dn, ac);
          it.d  = op[1] ? ~bg : bg;
          it.at = ac ? (dn ? "R7" : "R6") : (dn ? "R5" : "R4");
          it.ot = (n == MAX_OPS) ? "R12" : "R3";
          q.push_back(it);
        end
      end
    end
  endtask

  task automatic step_check();
    bit exp_done = 0, exp_f;
    @(negedge clk);
    cyc++;
    if (cyc > WD_LIMIT) timeout = 1;
    if (cd > 0) begin
      cd--;
      if (cd == 0) begin exp_done = 1; cd = -1; end
    end
    chk(done == exp_done, "R11", "done", done, exp_done);
    if (q.size() > 0) begin
      acc_t it = q.pop_front();
      chk(busy == 1'b1, "R2", "busy", busy, 1);
      chk(mem_en == 1'b1, "R8", "mem_en", mem_en, 1);
      chk(mem_we == it.we, it.ot, "op kind", mem_we, it.we);
      chk(int'(addr) == it.a, it.at, "address", addr, it.a);
      if (it.we) chk(wdata == it.d, "R9", "write data", wdata, it.d);
      else if (((mem[it.a] ^ ((it.a == int'(f_addr)) ? f_mask : '0)) != it.d) && !exp_fail) begin
        exp_fail = 1; exp_faddr = it.a; fail_cyc = cyc;
      end
      if (q.size() == 0) cd = 2;
    end else begin
      chk(mem_en == 1'b0, "R11", "idle mem_en", mem_en, 0);
      chk(busy == 1'b0, "R11", "idle busy", busy, 0);
    end
    exp_f = exp_fail && (cyc >= fail_cyc + 2);
    chk(fail == exp_f, "R10", "fail", fail, exp_f);
    if (exp_f) chk(int'(fail_addr) == exp_faddr, "R10", "fail_addr", fail_addr, exp_faddr);
  endtask

  task automatic run(logic [MAX_ELEM*EW-1:0] p, int last, logic [DATA_W-1:0] b,
                     int fa, logic [DATA_W-1:0] fm, int poke);
    int k = 0;
    prog = p; last_elem = ELC_W'(last); bg = b;
    f_addr = ADDR_W'(fa); f_mask = fm;
    build();
    exp_fail = 0;
    start = 1'b1;
    step_check();
    start = 1'b0;
    while ((q.size() > 0 || cd >= 0) && !timeout) begin
      k++;
      if (k == poke) start = 1'b1;  // R2: ignored while busy
      step_check();
      start = 1'b0;
    end
    repeat (2) step_check();
  endtask

  initial begin
    logic [MAX_ELEM*EW-1:0] p;
    for (int i = 0; i < N; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(busy == 0 && mem_en == 0, "R1", "reset busy/en", {busy, mem_en}, 0);
    chk(done == 0 && fail == 0, "R1", "reset done/fail", {done, fail}, 0);
    chk(fail_addr == 0, "R1", "reset fail_addr", fail_addr, 0);
    rst_n = 1'b1;
    repeat (3) step_check();

    // MATS+, linear, clean
    p = '0;
    p[0*EW +: EW] = mk(ANY, 0, 1, {6'b0, W0});
    p[1*EW +: EW] = mk(UP,  0, 2, {4'b0, W1, R0});
    p[2*EW +: EW] = mk(DN,  0, 2, {4'b0, W0, R1});
    run(p, 2, 8'h00, 0, 8'h00, 0);

    // MATS+ with a fault on the last descending address
    run(p, 2, 8'h3C, 0, 8'h40, 0);

    // March C- with a fault and a start request mid-run
    p = '0;
    p[0*EW +: EW] = mk(ANY, 0, 1, {6'b0, W0});
    p[1*EW +: EW] = mk(UP,  0, 2, {4'b0, W1, R0});
    p[2*EW +: EW] = mk(UP,  0, 2, {4'b0, W0, R1});
    p[3*EW +: EW] = mk(DN,  0, 2, {4'b0, W1, R0});
    p[4*EW +: EW] = mk(DN,  0, 2, {4'b0, W0, R1});
    p[5*EW +: EW] = mk(ANY, 0, 1, {6'b0, R0});
    run(p, 5, 8'h55, 5, 8'h01, 10);

    // address-complement up and down with a fault
    p = '0;
    p[0*EW +: EW] = mk(ANY, 0, 1, {6'b0, W0});
    p[1*EW +: EW] = mk(UP,  1, 2, {4'b0, W1, R0});
    p[2*EW +: EW] = mk(DN,  1, 2, {4'b0, W0, R1});
    p[3*EW +: EW] = mk(UP,  0, 1, {6'b0, R0});
    run(p, 3, 8'hA5, 9, 8'h80, 0);

    // full-length elements with three reads; clean run clears the flag
    p = '0;
    p[0*EW +: EW] = mk(UP, 0, 1, {6'b0, W1});
    p[1*EW +: EW] = mk(UP, 0, 4, {R0, R0, W0, R1});
    p[2*EW +: EW] = mk(DN, 1, 3, {2'b0, R1, W1, R0});
    run(p, 2, 8'h0F, 0, 8'h00, 0);

    if (timeout) chk(0, "R8", "watchdog", cyc, WD_LIMIT);
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule